// File: doc/BRIEF.md
# DMA Descriptor Fetch Unit

This block manages five DMA channels whose settings are held in 8-byte descriptors in memory instead of in configuration registers. Software writes two 16-bit table pointers, one for channel 0 alone and one for a 32-byte table that holds channels 1 to 4 back to back. Setting a channel's arm bit makes the unit read that channel's descriptor over a byte-wide memory read port. The channel then presents its current source and destination addresses to an external data mover.

The mover selects a channel and pulses a step input once per completed transfer. The unit advances both addresses by the configured mode and counts the transfer. When the count is used up, it disarms the channel and, if the descriptor asks for it, raises a shared interrupt flag. The length can be fixed in the descriptor or taken from the first source byte. An abort write to the arm register stops the chosen channels at any point, including during the descriptor fetch.

The memory read port has a fixed latency of one cycle. Data for an address driven with `mem_req_o` high at one rising edge must be on `mem_rdata_i` before the next rising edge. Register writes are single-cycle strobes. Register reads are combinational.

Top module: `dma_desc_unit`

## Requirements
- R1: After reset the arm register (address 4) and the interrupt flag register (address 5) read 0. `mem_req_o`, `ready_o` and `irq_o` are 0.
- R2: Channel 0's descriptor is read from base0 (addresses 1:0, high:low) through base0+7. Channel n (1 to 4) is read from base1 (addresses 3:2) + 8*(n-1) through that address + 7. The eight reads are issued on consecutive cycles in ascending address order.
- R3: No descriptor read is issued before a channel is armed. Setting the arm bit of a channel that is already armed issues no read.
- R4: Descriptor byte layout:
  - Bytes 0/1 hold the source address (high byte first).
  - Bytes 2/3 hold the destination address (high byte first).
  - Byte 4 holds bit 7 = variable length, bit 6 = 8-bit length, and bits 4:0 = length[12:8].
  - Byte 5 holds length[7:0].
  - Byte 6 holds bits 1:0 = source mode, bits 3:2 = destination mode, and bit 4 = interrupt mask.
  - After the fetch, `ready_o` is 1 for the selected channel, and the address outputs show the descriptor addresses.
- R5: Address mode encoding: 0 holds the address, 1 adds 1, 2 adds 2, and 3 subtracts 1. The change is applied to the address after each step.
- R6: With fixed length L (L >= 1), the channel finishes on step L. On that step it clears its own arm bit and drops `ready_o`.
- R7: With variable length, the first step's data byte gives N. N is all 8 bits when the 8-bit length bit is 1, and the low 7 bits otherwise. The channel finishes after N+1 steps in total.
- R8: On finishing, the shared flag (address 5, bit 0) is set only if the interrupt mask is 1. `irq_o` equals flag AND `irq_en_i`. Writing 1 to address 5 bit 0 clears the flag.
- R9: Writing the arm register with bit 7 = 1 disarms exactly the channels whose bits 4:0 are 1 in that write. The other channels keep their arm state, so 0x03 then 0x81 leaves 0x02. Writing with bit 7 = 0 sets the listed arm bits and never clears any.
- R10: An abort stops a descriptor fetch or a transfer in progress without setting the flag. Re-arming fetches the descriptor anew.
- R11: A step on a channel that is not ready has no effect on that channel's addresses or count.
- R12: When several channels wait for a fetch, the lowest-numbered channel is fetched first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address (0..3 pointers, 4 arm, 5 flag) |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i |
| mem_req_o | output | 1 | Descriptor byte read request |
| mem_addr_o | output | 16 | Descriptor byte address |
| mem_rdata_i | input | 8 | Read data, one cycle after the request |
| sel_ch_i | input | 3 | Channel selected by the data mover |
| step_i | input | 1 | One transfer done on the selected channel |
| step_data_i | input | 8 | Source byte of that transfer (length byte on a variable first step) |
| ready_o | output | 1 | Selected channel holds a loaded descriptor |
| src_addr_o | output | 16 | Current source address of the selected channel |
| dst_addr_o | output | 16 | Current destination address of the selected channel |
| irq_en_i | input | 1 | Global DMA interrupt enable |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions rely on the mover stepping only a channel that shows `ready_o`. They also rely on the memory answering every request exactly one cycle later. The stimulus respects this and never relies on reads being accepted at any other time. Register writes in the bench are one-cycle strobes separated by idle cycles, so an abort never coincides with a step on the same channel except where a test chooses it. Every descriptor fetch is allowed to run to completion before the next check, unless the test is about aborting a fetch.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int AW         = 16;
  localparam int LW         = 13;
  localparam int DESC_BYTES = 8;

  localparam logic [2:0] REG_B0L = 3'd0;
  localparam logic [2:0] REG_B0H = 3'd1;
  localparam logic [2:0] REG_B1L = 3'd2;
  localparam logic [2:0] REG_B1H = 3'd3;
  localparam logic [2:0] REG_ARM = 3'd4;
  localparam logic [2:0] REG_IRQ = 3'd5;

  typedef enum logic [1:0] {
    AM_HOLD = 2'd0,
    AM_INC1 = 2'd1,
    AM_INC2 = 2'd2,
    AM_DEC1 = 2'd3
  } amode_e;

  typedef struct packed {
    logic [AW-1:0] src;
    logic [AW-1:0] dst;
    logic          vlen;
    logic          m8;
    logic [LW-1:0] len;
    amode_e        smode;
    amode_e        dmode;
    logic          imask;
  } desc_t;

  function automatic logic [AW-1:0] next_addr(input logic [AW-1:0] a, input amode_e m);
    case (m)
      AM_INC1: next_addr = a + AW'(1);
      AM_INC2: next_addr = a + AW'(2);
      AM_DEC1: next_addr = a - AW'(1);
      default: next_addr = a;
    endcase
  endfunction
endpackage

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs
  import dma_pkg::*;
#(
  parameter int N_CH = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [2:0]      addr_i,
  input  logic [7:0]      wdata_i,
  input  logic [N_CH-1:0] done_i,
  input  logic            irq_set_i,
  output logic [N_CH-1:0] arm_o,
  output logic [N_CH-1:0] rise_o,
  output logic [N_CH-1:0] abort_o,
  output logic [AW-1:0]   base0_o,
  output logic [AW-1:0]   base1_o,
  output logic            irq_flag_o,
  output logic [7:0]      rdata_o
);
  logic [N_CH-1:0] arm_q;
  logic [AW-1:0]   base0_q, base1_q;
  logic            irq_q;
  logic            arm_wr;

  assign arm_wr  = we_i && (addr_i == REG_ARM);
  assign abort_o = (arm_wr && wdata_i[7])  ? wdata_i[N_CH-1:0] : '0;
  assign rise_o  = (arm_wr && !wdata_i[7]) ? (wdata_i[N_CH-1:0] & ~arm_q) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q   <= '0;
      base0_q <= '0;
      base1_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      // abort and completion both beat a set in the same cycle
      arm_q <= (arm_q | rise_o) & ~abort_o & ~done_i;
      if (we_i) begin
        case (addr_i)
          REG_B0L: base0_q[7:0]  <= wdata_i;
          REG_B0H: base0_q[15:8] <= wdata_i;
          REG_B1L: base1_q[7:0]  <= wdata_i;
          REG_B1H: base1_q[15:8] <= wdata_i;
          default: ;
        endcase
      end
      if (irq_set_i)                                  irq_q <= 1'b1;
      else if (we_i && addr_i == REG_IRQ && wdata_i[0]) irq_q <= 1'b0;
    end
  end

  always_comb begin
    case (addr_i)
      REG_B0L: rdata_o = base0_q[7:0];
      REG_B0H: rdata_o = base0_q[15:8];
      REG_B1L: rdata_o = base1_q[7:0];
      REG_B1H: rdata_o = base1_q[15:8];
      REG_ARM: rdata_o = 8'(arm_q);
      REG_IRQ: rdata_o = {7'd0, irq_q};
      default: rdata_o = 8'd0;
    endcase
  end

  assign arm_o      = arm_q;
  assign base0_o    = base0_q;
  assign base1_o    = base1_q;
  assign irq_flag_o = irq_q;
endmodule

// File: rtl/dma_desc_fetch.sv
module dma_desc_fetch
  import dma_pkg::*;
#(
  parameter int N_CH = 5,
  parameter int CW   = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] rise_i,
  input  logic [N_CH-1:0] abort_i,
  input  logic [AW-1:0]   base0_i,
  input  logic [AW-1:0]   base1_i,
  input  logic [7:0]      mem_rdata_i,
  output logic            mem_req_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic            load_o,
  output logic [CW-1:0]   load_ch_o,
  output desc_t           desc_o
);
  localparam int IW = $clog2(DESC_BYTES) + 1;

  logic [N_CH-1:0] pend_q, pend_eff;
  logic            busy_q, cap_v_q, any;
  logic [CW-1:0]   ch_q, pick;
  logic [IW-1:0]   idx_q;
  logic [IW-2:0]   cap_idx_q;
  logic [AW-1:0]   ch_base;
  desc_t           desc_q;

  assign pend_eff = pend_q & ~abort_i;

  // lowest pending channel wins
  always_comb begin
    pick = '0;
    any  = 1'b0;
    for (int k = N_CH - 1; k >= 0; k--) begin
      if (pend_eff[k]) begin
        pick = CW'(k);
        any  = 1'b1;
      end
    end
  end

  assign ch_base    = (ch_q == '0) ? base0_i
                                   : base1_i + ((AW'(ch_q) - AW'(1)) << $clog2(DESC_BYTES));
  assign mem_req_o  = busy_q && (idx_q < IW'(DESC_BYTES));
  assign mem_addr_o = ch_base + AW'(idx_q[IW-2:0]);
  assign load_o     = busy_q && cap_v_q && (cap_idx_q == (IW-1)'(DESC_BYTES - 1)) && !abort_i[ch_q];
  assign load_ch_o  = ch_q;
  assign desc_o     = desc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q    <= '0;
      busy_q    <= 1'b0;
      cap_v_q   <= 1'b0;
      ch_q      <= '0;
      idx_q     <= '0;
      cap_idx_q <= '0;
      desc_q    <= '0;
    end else begin
      pend_q <= pend_eff | rise_i;
      if (busy_q) begin
        if (abort_i[ch_q]) begin
          busy_q  <= 1'b0;
          cap_v_q <= 1'b0;
        end else begin
          if (idx_q < IW'(DESC_BYTES)) idx_q <= idx_q + IW'(1);
          cap_v_q   <= mem_req_o;
          cap_idx_q <= idx_q[IW-2:0];
          if (cap_v_q) begin
            case (cap_idx_q)
              3'd0: desc_q.src[15:8] <= mem_rdata_i;
              3'd1: desc_q.src[7:0]  <= mem_rdata_i;
              3'd2: desc_q.dst[15:8] <= mem_rdata_i;
              3'd3: desc_q.dst[7:0]  <= mem_rdata_i;
              3'd4: begin
                desc_q.vlen          <= mem_rdata_i[7];
                desc_q.m8            <= mem_rdata_i[6];
                desc_q.len[LW-1:8]   <= mem_rdata_i[LW-9:0];
              end
              3'd5: desc_q.len[7:0]  <= mem_rdata_i;
              3'd6: begin
                desc_q.smode <= amode_e'(mem_rdata_i[1:0]);
                desc_q.dmode <= amode_e'(mem_rdata_i[3:2]);
                desc_q.imask <= mem_rdata_i[4];
              end
              default: ;
            endcase
            if (cap_idx_q == (IW-1)'(DESC_BYTES - 1)) begin
              busy_q  <= 1'b0;
              cap_v_q <= 1'b0;
            end
          end
        end
      end else if (any) begin
        busy_q  <= 1'b1;
        ch_q    <= pick;
        idx_q   <= '0;
        cap_v_q <= 1'b0;
        pend_q  <= (pend_eff | rise_i) & ~(N_CH'(1) << pick);
      end
    end
  end
endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  desc_t         desc_i,
  input  logic          abort_i,
  input  logic          step_i,
  input  logic [7:0]    step_data_i,
  output logic          ready_o,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic          done_o,
  output logic          imask_o
);
  logic          rdy_q, first_q, vlen_q, m8_q, imask_q;
  amode_e        smode_q, dmode_q;
  logic [AW-1:0] src_q, dst_q;
  logic [LW-1:0] rem_q, rem_nx;
  logic [7:0]    len_byte;
  logic          step_ok, fin;

  assign step_ok  = step_i && rdy_q && !abort_i;
  assign len_byte = m8_q ? step_data_i : {1'b0, step_data_i[6:0]};

  always_comb begin
    if (first_q && vlen_q) begin
      rem_nx = LW'(len_byte);
      fin    = (len_byte == 8'd0);
    end else begin
      rem_nx = rem_q - LW'(1);
      fin    = (rem_q <= LW'(1));
    end
  end

  assign done_o  = step_ok && fin;
  assign ready_o = rdy_q;
  assign src_o   = src_q;
  assign dst_o   = dst_q;
  assign imask_o = imask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q   <= 1'b0;
      first_q <= 1'b0;
      vlen_q  <= 1'b0;
      m8_q    <= 1'b0;
      imask_q <= 1'b0;
      smode_q <= AM_HOLD;
      dmode_q <= AM_HOLD;
      src_q   <= '0;
      dst_q   <= '0;
      rem_q   <= '0;
    end else if (abort_i) begin
      rdy_q <= 1'b0;
    end else if (load_i) begin
      rdy_q   <= 1'b1;
      first_q <= 1'b1;
      vlen_q  <= desc_i.vlen;
      m8_q    <= desc_i.m8;
      imask_q <= desc_i.imask;
      smode_q <= desc_i.smode;
      dmode_q <= desc_i.dmode;
      src_q   <= desc_i.src;
      dst_q   <= desc_i.dst;
      rem_q   <= desc_i.len;
    end else if (step_ok) begin
      src_q   <= next_addr(src_q, smode_q);
      dst_q   <= next_addr(dst_q, dmode_q);
      rem_q   <= rem_nx;
      first_q <= 1'b0;
      if (fin) rdy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_desc_unit.sv
module dma_desc_unit
  import dma_pkg::*;
#(
  parameter int N_CH = 5
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [2:0]  reg_addr_i,
  input  logic [7:0]  reg_wdata_i,
  output logic [7:0]  reg_rdata_o,
  output logic        mem_req_o,
  output logic [15:0] mem_addr_o,
  input  logic [7:0]  mem_rdata_i,
  input  logic [2:0]  sel_ch_i,
  input  logic        step_i,
  input  logic [7:0]  step_data_i,
  output logic        ready_o,
  output logic [15:0] src_addr_o,
  output logic [15:0] dst_addr_o,
  input  logic        irq_en_i,
  output logic        irq_o
);
  localparam int CW = (N_CH > 1) ? $clog2(N_CH) : 1;

  logic [N_CH-1:0] arm, rise, abort_m, ch_rdy, ch_done, ch_imask;
  logic [AW-1:0]   base0, base1;
  logic [AW-1:0]   ch_src [N_CH];
  logic [AW-1:0]   ch_dst [N_CH];
  logic            irq_flag, load;
  logic [CW-1:0]   load_ch;
  desc_t           desc;

  dma_ctrl_regs #(.N_CH(N_CH)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .done_i     (ch_done),
    .irq_set_i  (|(ch_done & ch_imask)),
    .arm_o      (arm),
    .rise_o     (rise),
    .abort_o    (abort_m),
    .base0_o    (base0),
    .base1_o    (base1),
    .irq_flag_o (irq_flag),
    .rdata_o    (reg_rdata_o)
  );

  dma_desc_fetch #(.N_CH(N_CH), .CW(CW)) u_fetch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rise_i      (rise),
    .abort_i     (abort_m),
    .base0_i     (base0),
    .base1_i     (base1),
    .mem_rdata_i (mem_rdata_i),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .load_o      (load),
    .load_ch_o   (load_ch),
    .desc_o      (desc)
  );

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    dma_chan u_ch (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .load_i      (load && (load_ch == CW'(k))),
      .desc_i      (desc),
      .abort_i     (abort_m[k]),
      .step_i      (step_i && (sel_ch_i == 3'(k))),
      .step_data_i (step_data_i),
      .ready_o     (ch_rdy[k]),
      .src_o       (ch_src[k]),
      .dst_o       (ch_dst[k]),
      .done_o      (ch_done[k]),
      .imask_o     (ch_imask[k])
    );
  end

  always_comb begin
    ready_o    = 1'b0;
    src_addr_o = '0;
    dst_addr_o = '0;
    for (int k = 0; k < N_CH; k++) begin
      if (sel_ch_i == 3'(k)) begin
        ready_o    = ch_rdy[k];
        src_addr_o = ch_src[k];
        dst_addr_o = ch_dst[k];
      end
    end
  end

  assign irq_o = irq_flag & irq_en_i;
endmodule

// File: rtl/dma_desc_chk.sv
module dma_desc_chk #(
  parameter int N_CH = 5
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            reg_we_i,
  input logic [2:0]      reg_addr_i,
  input logic [7:0]      reg_wdata_i,
  input logic            mem_req_o,
  input logic [15:0]     mem_addr_o,
  input logic [N_CH-1:0] arm_i,
  input logic [N_CH-1:0] rdy_i,
  input logic [N_CH-1:0] done_i,
  input logic [N_CH-1:0] imask_i,
  input logic            irq_flag_i
);
  // R9
  abort_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 3'd4 && reg_wdata_i[7]) |=>
      (arm_i == ($past(arm_i) & ~$past(reg_wdata_i[N_CH-1:0]) & ~$past(done_i))));

  // R2
  ascend_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && $past(mem_req_o)) |-> (mem_addr_o == $past(mem_addr_o) + 16'd1));

  // R3
  rd_armed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (arm_i != '0));

  // R6
  ready_armed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_i & ~arm_i) == '0);

  // R8
  irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_flag_i) |-> $past((done_i & imask_i) != '0));
endmodule

bind dma_desc_unit dma_desc_chk #(.N_CH(N_CH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .mem_req_o   (mem_req_o),
  .mem_addr_o  (mem_addr_o),
  .arm_i       (arm),
  .rdy_i       (ch_rdy),
  .done_i      (ch_done),
  .imask_i     (ch_imask),
  .irq_flag_i  (irq_flag)
);

// File: tb/sim_dma_desc_unit.sv
module sim_dma_desc_unit;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0, reg_rdata;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata = '0;
  logic [2:0]  sel_ch = '0;
  logic        step = 1'b0;
  logic [7:0]  step_data = '0;
  logic        ready;
  logic [15:0] src_addr, dst_addr;
  logic        irq_en = 1'b0, irq;

  int total = 0, bad = 0, cyc = 0;
  logic [7:0]  mem [256];
  logic [15:0] log_a [64];
  int          log_n = 0;

  always #(CLK_P/2) clk = ~clk;

  dma_desc_unit u0 (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .mem_req_o(mem_req),
    .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata), .sel_ch_i(sel_ch),
    .step_i(step), .step_data_i(step_data), .ready_o(ready),
    .src_addr_o(src_addr), .dst_addr_o(dst_addr), .irq_en_i(irq_en), .irq_o(irq)
  );

  always @(posedge clk) begin
    cyc = cyc + 1;
    mem_rdata <= mem[mem_addr[7:0]];
    if (mem_req && log_n < 64) begin
      log_a[log_n] = mem_addr;
      log_n = log_n + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic stp(input logic [2:0] ch, input logic [7:0] d);
    @(negedge clk);
    sel_ch = ch; step = 1'b1; step_data = d;
    @(negedge clk);
    step = 1'b0;
  endtask

  task automatic look(input logic [2:0] ch);
    sel_ch = ch;
    #1;
  endtask

  task automatic put_desc(input logic [7:0] a, input logic [15:0] s, input logic [15:0] d,
                          input logic vl, input logic m8, input logic [12:0] len,
                          input logic [1:0] sm, input logic [1:0] dm, input logic im);
    mem[a]      = s[15:8];
    mem[a + 1]  = s[7:0];
    mem[a + 2]  = d[15:8];
    mem[a + 3]  = d[7:0];
    mem[a + 4]  = {vl, m8, 1'b0, len[12:8]};
    mem[a + 5]  = len[7:0];
    mem[a + 6]  = {3'd0, im, dm, sm};
    mem[a + 7]  = 8'hA5;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(3'd4, v); chk("R1 arm", v, 0);
    rd(3'd5, v); chk("R1 flag", v, 0);
    look(3'd0);
    chk("R1 mem_req", mem_req, 0);
    chk("R1 ready", ready, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_fetch();
    logic [7:0] v;
    put_desc(8'h40, 16'h1000, 16'h2000, 0, 0, 13'd2, 2'd0, 2'd1, 1);
    put_desc(8'h90, 16'h3000, 16'h4000, 0, 0, 13'd3, 2'd2, 2'd3, 0);
    wr(3'd0, 8'h40); wr(3'd1, 8'h00); wr(3'd2, 8'h80); wr(3'd3, 8'h00);
    log_n = 0;
    idle(4);
    chk("R3 no read before arm", log_n, 0);
    wr(3'd4, 8'h01);
    idle(12);
    chk("R2 ch0 read count", log_n, 8);
    for (int k = 0; k < 8; k++) chk("R2 ch0 addr", log_a[k], 16'h0040 + k);
    look(3'd0);
    chk("R4 ch0 ready", ready, 1);
    chk("R4 ch0 src", src_addr, 16'h1000);
    chk("R4 ch0 dst", dst_addr, 16'h2000);
    log_n = 0;
    wr(3'd4, 8'h08);
    idle(12);
    chk("R2 ch3 read count", log_n, 8);
    for (int k = 0; k < 8; k++) chk("R2 ch3 addr", log_a[k], 16'h0090 + k);
    look(3'd3);
    chk("R4 ch3 ready", ready, 1);
    chk("R4 ch3 src", src_addr, 16'h3000);
    chk("R4 ch3 dst", dst_addr, 16'h4000);
    log_n = 0;
    wr(3'd4, 8'h09);
    idle(12);
    chk("R3 rearm no read", log_n, 0);
    rd(3'd4, v); chk("R3 arm kept", v, 8'h09);
  endtask

  task automatic t_modes();
    logic [7:0] v;
    irq_en = 1'b1;
    stp(3'd3, 8'h00); look(3'd3);
    chk("R5 inc2 src", src_addr, 16'h3002);
    chk("R5 dec1 dst", dst_addr, 16'h3FFF);
    stp(3'd3, 8'h00); look(3'd3);
    chk("R5 inc2 src 2", src_addr, 16'h3004);
    chk("R5 dec1 dst 2", dst_addr, 16'h3FFE);
    chk("R6 ready before end", ready, 1);
    stp(3'd3, 8'h00); look(3'd3);
    chk("R6 ch3 done ready", ready, 0);
    rd(3'd4, v); chk("R6 ch3 disarmed", v, 8'h01);
    rd(3'd5, v); chk("R8 masked no flag", v, 0);
    stp(3'd0, 8'h00); look(3'd0);
    chk("R5 hold src", src_addr, 16'h1000);
    chk("R5 inc1 dst", dst_addr, 16'h2001);
    stp(3'd0, 8'h00); look(3'd0);
    chk("R6 ch0 done ready", ready, 0);
    rd(3'd4, v); chk("R6 ch0 disarmed", v, 8'h00);
    rd(3'd5, v); chk("R8 flag set", v, 8'h01);
    chk("R8 irq with enable", irq, 1);
    irq_en = 1'b0; #1;
    chk("R8 irq gated", irq, 0);
    wr(3'd5, 8'h01);
    rd(3'd5, v); chk("R8 flag cleared", v, 0);
    irq_en = 1'b1;
  endtask

  task automatic t_vlen();
    put_desc(8'h80, 16'h5000, 16'h6000, 1, 0, 13'h055, 2'd1, 2'd1, 0);
    put_desc(8'h88, 16'h5100, 16'h6100, 1, 1, 13'h000, 2'd1, 2'd1, 0);
    wr(3'd4, 8'h06);
    idle(25);
    stp(3'd1, 8'h83);
    stp(3'd1, 8'h00);
    stp(3'd1, 8'h00);
    look(3'd1);
    chk("R7 7-bit len still ready", ready, 1);
    chk("R7 src after 3", src_addr, 16'h5003);
    stp(3'd1, 8'h00); look(3'd1);
    chk("R7 7-bit len done", ready, 0);
    stp(3'd2, 8'h81);
    stp(3'd2, 8'h00); look(3'd2);
    chk("R7 8-bit len not done at 2", ready, 1);
    for (int k = 0; k < 127; k++) stp(3'd2, 8'h00);
    look(3'd2);
    chk("R7 8-bit len ready at 129", ready, 1);
    stp(3'd2, 8'h00); look(3'd2);
    chk("R7 8-bit len done at 130", ready, 0);
  endtask

  task automatic t_ignore();
    logic [7:0] v;
    put_desc(8'h98, 16'h7000, 16'h7800, 0, 0, 13'd5, 2'd1, 2'd1, 0);
    stp(3'd4, 8'h00); look(3'd4);
    chk("R11 unarmed step ready", ready, 0);
    rd(3'd4, v); chk("R11 unarmed step arm", v, 0);
    wr(3'd4, 8'h10);
    stp(3'd4, 8'h00);
    idle(12); look(3'd4);
    chk("R11 early step ready", ready, 1);
    chk("R11 early step src", src_addr, 16'h7000);
    wr(3'd4, 8'h90);
  endtask

  task automatic t_abort();
    logic [7:0] v;
    put_desc(8'h40, 16'h1000, 16'h2000, 0, 0, 13'd100, 2'd1, 2'd1, 1);
    put_desc(8'h80, 16'h5000, 16'h6000, 0, 0, 13'd100, 2'd1, 2'd1, 1);
    wr(3'd4, 8'h03);
    idle(25);
    rd(3'd4, v); chk("R9 both armed", v, 8'h03);
    wr(3'd4, 8'h81);
    rd(3'd4, v); chk("R9 only ch1 left", v, 8'h02);
    look(3'd0); chk("R9 ch0 stopped", ready, 0);
    look(3'd1); chk("R9 ch1 kept", ready, 1);
    wr(3'd4, 8'h82);
    rd(3'd4, v); chk("R9 all off", v, 0);
    look(3'd1); chk("R9 ch1 stopped", ready, 0);
  endtask

  task automatic t_abort_mid();
    logic [7:0] v;
    log_n = 0;
    wr(3'd4, 8'h01);
    idle(2);
    wr(3'd4, 8'h81);
    idle(12);
    chk("R10 fetch cut short", (log_n < 8), 1);
    look(3'd0); chk("R10 aborted fetch ready", ready, 0);
    rd(3'd4, v); chk("R10 aborted fetch arm", v, 0);
    put_desc(8'h90, 16'h3000, 16'h4000, 0, 0, 13'd3, 2'd1, 2'd1, 1);
    wr(3'd4, 8'h08);
    idle(12);
    stp(3'd3, 8'h00);
    wr(3'd4, 8'h88);
    rd(3'd4, v); chk("R10 xfer abort arm", v, 0);
    rd(3'd5, v); chk("R10 xfer abort no flag", v, 0);
    chk("R10 xfer abort no irq", irq, 0);
    wr(3'd4, 8'h08);
    idle(12); look(3'd3);
    chk("R10 refetch ready", ready, 1);
    chk("R10 refetch src", src_addr, 16'h3000);
    wr(3'd4, 8'h88);
  endtask

  task automatic t_order();
    log_n = 0;
    wr(3'd4, 8'h18);
    idle(25);
    chk("R12 total reads", log_n, 16);
    chk("R12 ch3 first", log_a[0], 16'h0090);
    chk("R12 ch4 second", log_a[8], 16'h0098);
    wr(3'd4, 8'h98);
  endtask

  initial begin
    for (int k = 0; k < 256; k++) mem[k] = 8'h00;
    idle(3);
    rst_ni = 1'b1;
    idle(1);
    t_reset();
    t_fetch();
    t_modes();
    t_vlen();
    t_ignore();
    t_abort();
    t_abort_mid();
    t_order();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc > 50000);
    total++;
    bad++;
    $display("FAIL watchdog act=%0d exp=<50000", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule